// File: doc/BRIEF.md
# One-time-writable byte memory model

This block is a clocked, synthesizable stand-in for an ultraviolet-erasable byte-wide read-only memory. It holds a word array that reads as all ones after reset or erase. Its three control inputs are active-low chip select, active-low output gate and a program-supply flag. From these it decodes read, output-disable, standby, program, verify, optional-verify and program-inhibit. A fourth flag marks a high voltage on address line 9. When that flag is set during a plain read, the block returns fixed identifier bytes in place of array data.

The data bus is modelled as the two sides of a bidirectional pad. `data_i` carries program data into the block. `data_o` together with `drive_en_o` is what the block would put on the pad. A program pulse is a falling edge of chip select while the program supply is high and the output gate is high. It can only clear bits: the cell becomes the AND of its old content and the presented byte. An erase strobe held for one clock sets every cell back to all ones. Analog levels and access times are replaced by logical flags and a parameterised number of clock cycles of output latency. The full part uses `ADDR_W = 15`. The default is smaller so the model stays light.

Top module: `eprom_model`

## Requirements
- R1: After reset `drive_en_o` is 0, `data_o` is 0, and every array word reads as all ones.
- R2: With `ce_ni`=0, `oe_ni`=0, `vpp_hi_i`=0 and `a9_hv_i`=0 (read), the block drives the array word at `addr_i`.
- R3: With `ce_ni`=0, `oe_ni`=1 and `vpp_hi_i`=0 (output disable), `drive_en_o` is 0 and `data_o` is 0.
- R4: With `ce_ni`=1 and `vpp_hi_i`=0 (standby), `drive_en_o` is 0 and `data_o` is 0 whatever `oe_ni` is.
- R5: With `vpp_hi_i`=1 and `oe_ni`=1, the first clock in which `ce_ni` is low after being high writes the byte from `data_i` to the word at `addr_i`. Later cycles of the same low pulse write nothing, even if `data_i` changes. The bus is not driven in program mode.
- R6: A write stores old AND new, so 1 bits in the data leave cells unchanged and a 0 bit can never be set back to 1 by programming.
- R7: With `vpp_hi_i`=1 and `oe_ni`=0, the block drives the array word at `addr_i`. This holds with `ce_ni`=1 (verify) and with `ce_ni`=0 (optional verify, which does not write).
- R8: With `vpp_hi_i`=1, `ce_ni`=1 and `oe_ni`=1 (program inhibit), the bus is not driven and no cell changes.
- R9: In a read with `a9_hv_i`=1, the block drives `MFG_CODE` (default 0x20) when `addr_i[0]`=0 and `DEV_CODE` (default 0x04) when `addr_i[0]`=1.
- R10: An `erase_i` clock sets every word to all ones. In that clock no write happens and the bus is not driven.
- R11: Inputs applied before a rising clock edge appear on `drive_en_o`/`data_o` after exactly `RD_LAT` rising edges. Before that, the outputs still reflect the earlier inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output gate, active low |
| vpp_hi_i | input | 1 | Program supply at its high level |
| a9_hv_i | input | 1 | High voltage present on address line 9 |
| erase_i | input | 1 | Erase whole array to all ones |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Program data from the pad |
| data_o | output | DATA_W | Data toward the pad, 0 when not driven |
| drive_en_o | output | 1 | Registered pad drive enable |

## Verification
The bench builds the block with `ADDR_W = 6` and `RD_LAT = 3`. The 64-word array is small enough that every word can be read back after an erase, and the top address can be programmed as a boundary case. A latency of three makes the "not yet" window from R11 several cycles long, so a pipeline that is one stage short or long shows up at the sampled edge. The identifier tests use address pairs that differ only in bit 0, which separates the two codes from ordinary array contents.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_OUTDIS,
        M_PROG,
        M_VERIFY,
        M_OPTVER,
        M_INHIBIT,
        M_SIG
    } mode_e;

    // Control decode: supply level selects the program-side table.
    function automatic mode_e decode_mode(input logic ce_n, input logic oe_n,
                                          input logic vpp_hi, input logic a9_hv);
        mode_e m;
        if (vpp_hi) begin
            case ({ce_n, oe_n})
                2'b00:   m = M_OPTVER;
                2'b01:   m = M_PROG;
                2'b10:   m = M_VERIFY;
                default: m = M_INHIBIT;
            endcase
        end else if (ce_n) begin
            m = M_STANDBY;
        end else if (oe_n) begin
            m = M_OUTDIS;
        end else if (a9_hv) begin
            m = M_SIG;
        end else begin
            m = M_READ;
        end
        return m;
    endfunction

    function automatic logic mode_drives(input mode_e m);
        return (m == M_READ) || (m == M_SIG) || (m == M_VERIFY) || (m == M_OPTVER);
    endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ce_ni,
    input  logic oe_ni,
    input  logic vpp_hi_i,
    input  logic a9_hv_i,
    input  logic erase_i,
    output logic drive_o,
    output logic sig_o,
    output logic prog_strobe_o
);

    typedef struct packed {
        logic ce_prev;
    } dec_state_t;

    dec_state_t st_d, st_q;
    mode_e      mode;

    always_comb begin
        mode          = decode_mode(ce_ni, oe_ni, vpp_hi_i, a9_hv_i);
        st_d.ce_prev  = ce_ni;
        drive_o       = !erase_i && mode_drives(mode);
        sig_o         = (mode == M_SIG);
        // a pulse writes once, at its leading (falling) edge
        prog_strobe_o = !erase_i && (mode == M_PROG) && st_q.ce_prev;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ce_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              erase_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (erase_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] = '1;
            end
        end else if (wr_en_i) begin
            // bits can only fall: old AND new
            mem_d[wr_addr_i] = mem_q[wr_addr_i] & wr_data_i;
        end
        rd_data_o = mem_q[rd_addr_i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/eprom_out_pipe.sv
module eprom_out_pipe #(
    parameter int DATA_W = 8,
    parameter int RD_LAT = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              en_o,
    output logic [DATA_W-1:0] word_o
);

    localparam int STG_W = DATA_W + 1;

    logic [STG_W-1:0] stg_d [RD_LAT];
    logic [STG_W-1:0] stg_q [RD_LAT];

    for (genvar g = 0; g < RD_LAT; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_comb begin
                stg_d[g] = {en_i, (en_i ? word_i : {DATA_W{1'b0}})};
            end
        end else begin : g_tail
            always_comb begin
                stg_d[g] = stg_q[g-1];
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stg_q[g] <= '0;
            end else begin
                stg_q[g] <= stg_d[g];
            end
        end
    end

    always_comb begin
        en_o   = stg_q[RD_LAT-1][DATA_W];
        word_o = stg_q[RD_LAT-1][DATA_W-1:0];
    end

endmodule

// File: rtl/eprom_model.sv
module eprom_model #(
    parameter int              ADDR_W   = 10,
    parameter int              DATA_W   = 8,
    parameter int              RD_LAT   = 2,
    parameter logic [DATA_W-1:0] MFG_CODE = 8'h20,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h04
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_ni,
    input  logic              oe_ni,
    input  logic              vpp_hi_i,
    input  logic              a9_hv_i,
    input  logic              erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              drive_en_o
);

    logic              drive;
    logic              sig_sel;
    logic              wr_en;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] out_word;

    eprom_mode_dec dec_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .ce_ni         (ce_ni),
        .oe_ni         (oe_ni),
        .vpp_hi_i      (vpp_hi_i),
        .a9_hv_i       (a9_hv_i),
        .erase_i       (erase_i),
        .drive_o       (drive),
        .sig_o         (sig_sel),
        .prog_strobe_o (wr_en)
    );

    eprom_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) arr_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .erase_i   (erase_i),
        .wr_en_i   (wr_en),
        .wr_addr_i (addr_i),
        .wr_data_i (data_i),
        .rd_addr_i (addr_i),
        .rd_data_o (arr_word)
    );

    always_comb begin
        if (sig_sel) begin
            out_word = addr_i[0] ? DEV_CODE : MFG_CODE;
        end else begin
            out_word = arr_word;
        end
    end

    eprom_out_pipe #(
        .DATA_W (DATA_W),
        .RD_LAT (RD_LAT)
    ) pipe_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (drive),
        .word_i (out_word),
        .en_o   (drive_en_o),
        .word_o (data_o)
    );

endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ce_ni,
    input logic              oe_ni,
    input logic              vpp_hi_i,
    input logic              erase_i,
    input logic              drive,
    input logic              wr_en,
    input logic [DATA_W-1:0] data_o,
    input logic              drive_en_o
);

    // R4
    standby_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_ni && !vpp_hi_i) |-> !drive);

    // R8
    inhibit_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vpp_hi_i && ce_ni && oe_ni) |-> (!wr_en && !drive));

    // R3
    idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !drive_en_o |-> (data_o == '0));

    // R5
    one_write_per_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en |=> !wr_en);

    // R10
    erase_blocks_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        erase_i |-> (!wr_en && !drive));

    // R5
    write_needs_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en |-> (vpp_hi_i && !ce_ni && oe_ni));

endmodule

bind eprom_model eprom_model_chk #(.DATA_W(DATA_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .vpp_hi_i   (vpp_hi_i),
    .erase_i    (erase_i),
    .drive      (drive),
    .wr_en      (wr_en),
    .data_o     (data_o),
    .drive_en_o (drive_en_o)
);

// File: tb/eprom_model_tb_top.sv
`timescale 1ns/1ps
module eprom_model_tb_top;

    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int LAT = 3;
    localparam int NV  = 19;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, vpp, a9, erase;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          den;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    eprom_model #(
        .ADDR_W (AW),
        .DATA_W (DW),
        .RD_LAT (LAT)
    ) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ce_ni      (ce_n),
        .oe_ni      (oe_n),
        .vpp_hi_i   (vpp),
        .a9_hv_i    (a9),
        .erase_i    (erase),
        .addr_i     (addr),
        .data_i     (din),
        .data_o     (dout),
        .drive_en_o (den)
    );

    // {req[4], vpp, ce_n, oe_n, a9, addr[6], data[8], exp_en, exp_data[8]}
    localparam logic [30:0] VEC [NV] = '{
        {4'd2,  1'b0,1'b0,1'b0,1'b0, 6'd5,  8'h00, 1'b1, 8'hFF}, // R2 erased read
        {4'd5,  1'b1,1'b0,1'b1,1'b0, 6'd5,  8'hA5, 1'b0, 8'h00}, // R5 program
        {4'd5,  1'b0,1'b0,1'b0,1'b0, 6'd5,  8'h00, 1'b1, 8'hA5}, // R5 read back
        {4'd6,  1'b1,1'b0,1'b1,1'b0, 6'd5,  8'h3C, 1'b0, 8'h00}, // R6 second pulse
        {4'd6,  1'b0,1'b0,1'b0,1'b0, 6'd5,  8'h00, 1'b1, 8'h24}, // R6 AND result
        {4'd6,  1'b1,1'b0,1'b1,1'b0, 6'd5,  8'hFF, 1'b0, 8'h00}, // R6 all-ones pulse
        {4'd6,  1'b0,1'b0,1'b0,1'b0, 6'd5,  8'h00, 1'b1, 8'h24}, // R6 unchanged
        {4'd3,  1'b0,1'b0,1'b1,1'b0, 6'd5,  8'h00, 1'b0, 8'h00}, // R3 output disable
        {4'd4,  1'b0,1'b1,1'b0,1'b0, 6'd5,  8'h00, 1'b0, 8'h00}, // R4 standby, gate low
        {4'd7,  1'b1,1'b1,1'b0,1'b0, 6'd5,  8'h00, 1'b1, 8'h24}, // R7 verify
        {4'd7,  1'b1,1'b0,1'b0,1'b0, 6'd5,  8'h00, 1'b1, 8'h24}, // R7 optional verify
        {4'd8,  1'b1,1'b1,1'b1,1'b0, 6'd5,  8'h00, 1'b0, 8'h00}, // R8 inhibit
        {4'd8,  1'b0,1'b0,1'b0,1'b0, 6'd5,  8'h00, 1'b1, 8'h24}, // R8 no write
        {4'd9,  1'b0,1'b0,1'b0,1'b1, 6'd4,  8'h00, 1'b1, 8'h20}, // R9 maker code
        {4'd9,  1'b0,1'b0,1'b0,1'b1, 6'd5,  8'h00, 1'b1, 8'h04}, // R9 device code
        {4'd9,  1'b0,1'b0,1'b0,1'b0, 6'd5,  8'h00, 1'b1, 8'h24}, // R9 flag off
        {4'd5,  1'b1,1'b0,1'b1,1'b0, 6'd63, 8'h00, 1'b0, 8'h00}, // R5 top address
        {4'd5,  1'b0,1'b0,1'b0,1'b0, 6'd63, 8'h00, 1'b1, 8'h00}, // R5 top read
        {4'd2,  1'b0,1'b0,1'b0,1'b0, 6'd0,  8'h00, 1'b1, 8'hFF}  // R2 bottom address
    };

    task automatic set_in(input logic v, input logic c, input logic o, input logic h,
                          input logic [AW-1:0] a, input logic [DW-1:0] d, input logic e);
        vpp = v; ce_n = c; oe_n = o; a9 = h; addr = a; din = d; erase = e;
    endtask

    task automatic idle();
        set_in(1'b0, 1'b1, 1'b1, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic check(input string tag, input logic en_exp, input logic [DW-1:0] d_exp);
        n_chk++;
        if (den !== en_exp || dout !== d_exp) begin
            n_fail++;
            $display("FAIL %s: en=%b data=%h expected en=%b data=%h", tag, den, dout, en_exp, d_exp);
        end
    endtask

    // apply at a falling edge, sample after LAT rising edges, then one idle clock
    task automatic run(input string tag, input logic v, input logic c, input logic o,
                       input logic h, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic e, input logic en_exp, input logic [DW-1:0] d_exp);
        @(negedge clk);
        set_in(v, c, o, h, a, d, e);
        if (e) begin
            @(negedge clk);
            erase = 1'b0;
            repeat (LAT - 1) @(posedge clk);
        end else begin
            repeat (LAT) @(posedge clk);
        end
        @(negedge clk);
        check(tag, en_exp, d_exp);
        idle();
        @(posedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs", 1'b0, 8'h00);
        rst_n = 1'b1;
        @(posedge clk);

        for (int i = 0; i < NV; i++) begin
            run($sformatf("R%0d vector %0d", VEC[i][30:27], i),
                VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23], VEC[i][22:17],
                VEC[i][16:9], 1'b0, VEC[i][8], VEC[i][7:0]);
        end

        // R11: output still quiet after LAT-1 edges, valid after LAT
        @(negedge clk);
        set_in(1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 8'h00, 1'b0);
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        check("R11 before latency", 1'b0, 8'h00);
        @(posedge clk);
        @(negedge clk);
        check("R11 at latency", 1'b1, 8'h24);
        idle();
        @(posedge clk);

        // R5: data changed mid-pulse is not written
        @(negedge clk);
        set_in(1'b1, 1'b0, 1'b1, 1'b0, 6'd10, 8'hF0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        din = 8'h00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R5 no drive in pulse", 1'b0, 8'h00);
        idle();
        @(posedge clk);
        run("R5 later pulse data ignored", 1'b0, 1'b0, 1'b0, 1'b0, 6'd10, 8'h00, 1'b0, 1'b1, 8'hF0);

        // R10: read during erase clock is not driven
        run("R10 erase clock quiet", 1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 8'h00, 1'b1, 1'b0, 8'h00);
        // R10: program pulse during erase clock does not write
        run("R10 erase with pulse", 1'b1, 1'b0, 1'b1, 1'b0, 6'd20, 8'h00, 1'b1, 1'b0, 8'h00);
        for (int a = 0; a < (1 << AW); a++) begin
            run($sformatf("R10 erased word %0d", a), 1'b0, 1'b0, 1'b0, 1'b0,
                a[AW-1:0], 8'h00, 1'b0, 1'b1, 8'hFF);
        end

        // R1: reset in the middle restores erased contents
        run("R1 pre-reset program", 1'b1, 1'b0, 1'b1, 1'b0, 6'd7, 8'h00, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run("R1 array ones after reset", 1'b0, 1'b0, 1'b0, 1'b0, 6'd7, 8'h00, 1'b0, 1'b1, 8'hFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule